// File: doc/BRIEF.md
# Posted-Write Peripheral Bus Bridge

This block connects a processor request port and a second (DMA) request port to a peripheral bus. Each access goes through two phases. In the first, the bridge presents the address and compares the width the addressed peripheral reports with the requested width. In the second, it runs the transfer and waits for the peripheral to report that it is ready or that it has aborted. When posting is enabled, a processor write is copied into the bridge's single job slot and acknowledged at once. The processor then continues while the bridge finishes the peripheral transfer.

A mode bit adds a register stage in front of both requesters, for high clock rates. A size mismatch or an aborted transfer records the address, the data and a control summary in read-only capture registers, and it can raise an interrupt. The capture keeps the first fault until software clears it. Eight 16-bit control and capture registers sit on a separate register port with a combinational read path.

Top module: `pbus_bridge`

## Requirements
- R1: After reset the registers read: byte offset 0x00 = 0xFF11, 0x04 = 0x0009, 0x08 = 0x0000, 0x0C = 0xFFFF, 0x10/0x14/0x18 = 0xFFFF, 0x1C = 0x00F8. A register read at an unaligned offset, or at any offset of 0x20 or above, returns 0.
- R2: When posting is on (bit 0 of offset 0x08), a processor write is acknowledged in the same cycle the bridge accepts it, before the peripheral transfer. That transfer follows later with unchanged address, size and data, and it holds those values steady until ready or abort.
- R3: When posting is off, a processor write is acknowledged in the cycle the peripheral reports ready. With the pipeline off and a peripheral that is ready on its second transfer cycle, this is 3 cycles after the request is raised.
- R4: The job slot holds one access. An access that arrives while a posted write is still pending waits until that write completes, and peripheral transfers occur in request order.
- R5: A read returns the peripheral's data on its port's rdata in the acknowledge cycle. It returns 0 on a size mismatch or an abort.
- R6: With the pipeline mode on (bit 0 of offset 0x0C), every request from either port is accepted exactly one cycle later than with the mode off.
- R7: Sizes are encoded 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. If the requested size differs from per_width, no transfer starts (per_req stays low), the access is acknowledged one cycle after acceptance, and the fault is recorded.
- R8: An aborted transfer is recorded and raises the interrupt, including a posted write that was already acknowledged.
- R9: On a fault with none pending, the capture registers load: 0x10 = address[15:0], 0x14 = write data[15:0], 0x18 = write data[31:16] (both 0 for reads), and 0x1C = {8'h00, posted, from DMA, aborted, reported width[1:0], requested size[1:0], write}. Later faults do not change them while one is pending.
- R10: irq equals "fault pending" AND bit 1 of offset 0x0C. Writing offset 0x0C with bit 2 set clears the pending fault; irq holds otherwise.
- R11: Register writes to offsets 0x10 to 0x1C have no effect.
- R12: When both ports request together, the processor is served first. DMA writes are never posted. The two acknowledges are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_size | input | 2 | Processor access size (0/1/2 = 8/16/32 bit) |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ack | output | 1 | Processor acknowledge pulse |
| cpu_rdata | output | DW | Processor read data, valid with cpu_ack |
| dma_req | input | 1 | DMA request, held until dma_ack |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_size | input | 2 | DMA access size |
| dma_addr | input | AW | DMA address |
| dma_wdata | input | DW | DMA write data |
| dma_ack | output | 1 | DMA acknowledge pulse |
| dma_rdata | output | DW | DMA read data, valid with dma_ack |
| per_req | output | 1 | Peripheral transfer active |
| per_we | output | 1 | Peripheral write |
| per_size | output | 2 | Peripheral access size |
| per_addr | output | AW | Peripheral address, also valid in the width-check cycle |
| per_wdata | output | DW | Peripheral write data |
| per_width | input | 2 | Width reported by the peripheral decoded from per_addr |
| per_ready | input | 1 | Peripheral transfer complete |
| per_abort | input | 1 | Peripheral transfer aborted |
| per_rdata | input | DW | Peripheral read data |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write |
| reg_off | input | RAW | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Fault interrupt |

## Verification
On every cycle, the bound checker enforces the following. No transfer runs with a width mismatch. A stalled transfer keeps its address and data. The two acknowledges never coincide. The interrupt and the captured fault stay frozen until a write to the enhanced control register. Latency is a different matter. That a posted write is acknowledged before its transfer, that a stalled access is delayed by exactly the pending work, that the pipeline adds one cycle, and the values read back from the capture registers can only be shown by the bench's scenarios, which compare each peripheral transfer in order against a scoreboard queue.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   localparam int NUM_REGS = 8;
   localparam int FIRST_RO = 4;
   localparam int IX_CTL   = 0;
   localparam int IX_ALLOC = 1;
   localparam int IX_CPUC  = 2;
   localparam int IX_ENH   = 3;
   localparam int IX_CADDR = 4;
   localparam int IX_CLO   = 5;
   localparam int IX_CHI   = 6;
   localparam int IX_CCTL  = 7;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CHK  = 2'd1,
      ST_XFR  = 2'd2
   } eng_st_e;

   // captured control summary, bit 0 = write ... bit 7 = posted
   typedef struct packed {
      logic       posted;
      logic       from_dma;
      logic       aborted;
      logic [1:0] dev_width;
      logic [1:0] req_size;
      logic       we;
   } cap_ctrl_t;

   function automatic logic [15:0] reg_reset(input int idx);
      case (idx)
         IX_CTL:   return 16'hFF11;
         IX_ALLOC: return 16'h0009;
         IX_CPUC:  return 16'h0000;
         IX_CCTL:  return 16'h00F8;
         default:  return 16'hFFFF;
      endcase
   endfunction

endpackage

// File: rtl/pbus_in_stage.sv
module pbus_in_stage #(
   parameter int AW       = 16,
   parameter int DW       = 32,
   parameter bit HAS_PIPE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pipe_en,
   input  logic          kill,
   input  logic          in_valid,
   input  logic          in_we,
   input  logic [1:0]    in_size,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_wdata,
   output logic          out_valid,
   output logic          out_we,
   output logic [1:0]    out_size,
   output logic [AW-1:0] out_addr,
   output logic [DW-1:0] out_wdata
);

   localparam int BUNDLE_W = 1 + 2 + AW + DW;

   if (HAS_PIPE) begin : g_pipe
      logic                valid_q;
      logic [BUNDLE_W-1:0] data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
         end else begin
            // an acknowledged request must not be seen a second time
            valid_q <= in_valid && !kill;
            data_q  <= {in_we, in_size, in_addr, in_wdata};
         end
      end

      always_comb begin
         if (pipe_en) begin
            out_valid = valid_q;
            {out_we, out_size, out_addr, out_wdata} = data_q;
         end else begin
            out_valid = in_valid;
            {out_we, out_size, out_addr, out_wdata} =
               {in_we, in_size, in_addr, in_wdata};
         end
      end
   end else begin : g_bypass
      logic unused_pins;
      assign unused_pins = ^{clk, rst_n, pipe_en, kill};
      assign out_valid = in_valid;
      assign out_we    = in_we;
      assign out_size  = in_size;
      assign out_addr  = in_addr;
      assign out_wdata = in_wdata;
   end

endmodule

// File: rtl/pbus_engine.sv
module pbus_engine
   import pbus_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          post_en,
   input  logic          c_valid,
   input  logic          c_we,
   input  logic [1:0]    c_size,
   input  logic [AW-1:0] c_addr,
   input  logic [DW-1:0] c_wdata,
   input  logic          d_valid,
   input  logic          d_we,
   input  logic [1:0]    d_size,
   input  logic [AW-1:0] d_addr,
   input  logic [DW-1:0] d_wdata,
   output logic          cpu_ack,
   output logic [DW-1:0] cpu_rdata,
   output logic          dma_ack,
   output logic [DW-1:0] dma_rdata,
   output logic          per_req,
   output logic          per_we,
   output logic [1:0]    per_size,
   output logic [AW-1:0] per_addr,
   output logic [DW-1:0] per_wdata,
   input  logic [1:0]    per_width,
   input  logic          per_ready,
   input  logic          per_abort,
   input  logic [DW-1:0] per_rdata,
   output logic          err_evt,
   output logic [AW-1:0] err_addr,
   output logic [DW-1:0] err_data,
   output cap_ctrl_t     err_ctrl
);

   eng_st_e       st_q;
   logic          j_we, j_dma, j_posted;
   logic [1:0]    j_size;
   logic [AW-1:0] j_addr;
   logic [DW-1:0] j_wdata;

   logic take_c, take_d, post_now, mismatch, xfr_end, done, good;

   always_comb begin
      take_c   = (st_q == ST_IDLE) && c_valid;
      take_d   = (st_q == ST_IDLE) && !c_valid && d_valid;
      post_now = take_c && c_we && post_en;
      mismatch = (st_q == ST_CHK) && (per_width != j_size);
      xfr_end  = (st_q == ST_XFR) && (per_ready || per_abort);
      done     = mismatch || xfr_end;
      good     = xfr_end && !per_abort;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         j_we     <= 1'b0;
         j_dma    <= 1'b0;
         j_posted <= 1'b0;
         j_size   <= '0;
         j_addr   <= '0;
         j_wdata  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (take_c) begin
                  {j_we, j_size, j_addr, j_wdata} <= {c_we, c_size, c_addr, c_wdata};
                  j_dma    <= 1'b0;
                  j_posted <= post_now;
                  st_q     <= ST_CHK;
               end else if (take_d) begin
                  {j_we, j_size, j_addr, j_wdata} <= {d_we, d_size, d_addr, d_wdata};
                  j_dma    <= 1'b1;
                  j_posted <= 1'b0;
                  st_q     <= ST_CHK;
               end
            end
            ST_CHK:  st_q <= mismatch ? ST_IDLE : ST_XFR;
            ST_XFR:  if (xfr_end) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cpu_ack   = post_now || (done && !j_dma && !j_posted);
      dma_ack   = done && j_dma;
      cpu_rdata = (good && !j_dma) ? per_rdata : '0;
      dma_rdata = (good &&  j_dma) ? per_rdata : '0;
      per_req   = (st_q == ST_XFR);
      per_we    = j_we;
      per_size  = j_size;
      per_addr  = j_addr;
      per_wdata = j_wdata;
      err_evt   = mismatch || (xfr_end && per_abort);
      err_addr  = j_addr;
      err_data  = j_we ? j_wdata : '0;
      err_ctrl  = '{posted:    j_posted,
                    from_dma:  j_dma,
                    aborted:   !mismatch,
                    dev_width: per_width,
                    req_size:  j_size,
                    we:        j_we};
   end

endmodule

// File: rtl/pbus_regs.sv
module pbus_regs
   import pbus_pkg::*;
#(
   parameter int RAW = 6,
   parameter int AW  = 16,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_en,
   input  logic           reg_we,
   input  logic [RAW-1:0] reg_off,
   input  logic [15:0]    reg_wdata,
   output logic [15:0]    reg_rdata,
   input  logic           err_evt,
   input  logic [AW-1:0]  err_addr,
   input  logic [DW-1:0]  err_data,
   input  cap_ctrl_t      err_ctrl,
   output logic           post_en,
   output logic           pipe_en,
   output logic           irq,
   output logic           err_pend,
   output logic [63:0]    cap_view
);

   localparam int IDXW = RAW - 2;

   logic [15:0]     rf_q [NUM_REGS];
   logic [IDXW-1:0] widx;
   logic            hit, wr_rw, clr;

   always_comb begin
      widx  = reg_off[RAW-1:2];
      hit   = (reg_off[1:0] == 2'b00) && (int'(widx) < NUM_REGS);
      wr_rw = reg_en && reg_we && hit && (int'(widx) < FIRST_RO);
      clr   = reg_en && reg_we && hit && (int'(widx) == IX_ENH) && reg_wdata[2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) rf_q[i] <= reg_reset(i);
         err_pend <= 1'b0;
      end else begin
         if (wr_rw) rf_q[widx[2:0]] <= reg_wdata;
         if (clr) begin
            err_pend <= 1'b0;
         end else if (err_evt && !err_pend) begin
            err_pend       <= 1'b1;
            rf_q[IX_CADDR] <= err_addr[15:0];
            rf_q[IX_CLO]   <= err_data[15:0];
            rf_q[IX_CHI]   <= err_data[31:16];
            rf_q[IX_CCTL]  <= {8'h00, err_ctrl};
         end
      end
   end

   always_comb begin
      reg_rdata = hit ? rf_q[widx[2:0]] : 16'h0000;
      post_en   = rf_q[IX_CPUC][0];
      pipe_en   = rf_q[IX_ENH][0];
      irq       = err_pend && rf_q[IX_ENH][1];
      cap_view  = {rf_q[IX_CADDR], rf_q[IX_CLO], rf_q[IX_CHI], rf_q[IX_CCTL]};
   end

endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
   import pbus_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 32,
   parameter int RAW      = 6,
   parameter bit HAS_PIPE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cpu_req,
   input  logic           cpu_we,
   input  logic [1:0]     cpu_size,
   input  logic [AW-1:0]  cpu_addr,
   input  logic [DW-1:0]  cpu_wdata,
   output logic           cpu_ack,
   output logic [DW-1:0]  cpu_rdata,
   input  logic           dma_req,
   input  logic           dma_we,
   input  logic [1:0]     dma_size,
   input  logic [AW-1:0]  dma_addr,
   input  logic [DW-1:0]  dma_wdata,
   output logic           dma_ack,
   output logic [DW-1:0]  dma_rdata,
   output logic           per_req,
   output logic           per_we,
   output logic [1:0]     per_size,
   output logic [AW-1:0]  per_addr,
   output logic [DW-1:0]  per_wdata,
   input  logic [1:0]     per_width,
   input  logic           per_ready,
   input  logic           per_abort,
   input  logic [DW-1:0]  per_rdata,
   input  logic           reg_en,
   input  logic           reg_we,
   input  logic [RAW-1:0] reg_off,
   input  logic [15:0]    reg_wdata,
   output logic [15:0]    reg_rdata,
   output logic           irq
);

   if (AW < 16 || AW > 32) begin : g_bad_aw
      $error("pbus_bridge: AW must lie in 16..32");
   end
   if (DW != 32) begin : g_bad_dw
      $error("pbus_bridge: DW must be 32 (two 16-bit capture halves)");
   end
   if (RAW < 6) begin : g_bad_raw
      $error("pbus_bridge: RAW must be at least 6");
   end

   logic          post_en, pipe_en, err_pend, err_evt;
   logic [63:0]   cap_view;
   logic [AW-1:0] err_addr;
   logic [DW-1:0] err_data;
   cap_ctrl_t     err_ctrl;

   logic          c_valid, c_we, d_valid, d_we;
   logic [1:0]    c_size, d_size;
   logic [AW-1:0] c_addr, d_addr;
   logic [DW-1:0] c_wdata, d_wdata;

   pbus_in_stage #(.AW(AW), .DW(DW), .HAS_PIPE(HAS_PIPE)) u_cpu_stage (
      .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .kill(cpu_ack),
      .in_valid(cpu_req), .in_we(cpu_we), .in_size(cpu_size),
      .in_addr(cpu_addr), .in_wdata(cpu_wdata),
      .out_valid(c_valid), .out_we(c_we), .out_size(c_size),
      .out_addr(c_addr), .out_wdata(c_wdata)
   );

   pbus_in_stage #(.AW(AW), .DW(DW), .HAS_PIPE(HAS_PIPE)) u_dma_stage (
      .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .kill(dma_ack),
      .in_valid(dma_req), .in_we(dma_we), .in_size(dma_size),
      .in_addr(dma_addr), .in_wdata(dma_wdata),
      .out_valid(d_valid), .out_we(d_we), .out_size(d_size),
      .out_addr(d_addr), .out_wdata(d_wdata)
   );

   pbus_engine #(.AW(AW), .DW(DW)) u_engine (
      .clk(clk), .rst_n(rst_n), .post_en(post_en),
      .c_valid(c_valid), .c_we(c_we), .c_size(c_size), .c_addr(c_addr), .c_wdata(c_wdata),
      .d_valid(d_valid), .d_we(d_we), .d_size(d_size), .d_addr(d_addr), .d_wdata(d_wdata),
      .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .dma_ack(dma_ack), .dma_rdata(dma_rdata),
      .per_req(per_req), .per_we(per_we), .per_size(per_size), .per_addr(per_addr),
      .per_wdata(per_wdata), .per_width(per_width), .per_ready(per_ready),
      .per_abort(per_abort), .per_rdata(per_rdata),
      .err_evt(err_evt), .err_addr(err_addr), .err_data(err_data), .err_ctrl(err_ctrl)
   );

   pbus_regs #(.RAW(RAW), .AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_en(reg_en), .reg_we(reg_we), .reg_off(reg_off),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .err_evt(err_evt), .err_addr(err_addr), .err_data(err_data), .err_ctrl(err_ctrl),
      .post_en(post_en), .pipe_en(pipe_en), .irq(irq),
      .err_pend(err_pend), .cap_view(cap_view)
   );

endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
   parameter int AW  = 16,
   parameter int DW  = 32,
   parameter int RAW = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cpu_ack,
   input logic           dma_ack,
   input logic           per_req,
   input logic           per_ready,
   input logic           per_abort,
   input logic [AW-1:0]  per_addr,
   input logic [DW-1:0]  per_wdata,
   input logic [1:0]     per_width,
   input logic [1:0]     per_size,
   input logic           irq,
   input logic           reg_en,
   input logic           reg_we,
   input logic [RAW-1:0] reg_off,
   input logic           err_pend,
   input logic [63:0]    cap_view
);

   logic enh_wr;
   assign enh_wr = reg_en && reg_we && (reg_off == RAW'(12));

   AST_NO_MISMATCH_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      per_req |-> (per_width == per_size)) else $error("mismatched transfer"); // R7

   AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      per_req && !per_ready && !per_abort |=>
         per_req && $stable(per_addr) && $stable(per_wdata)) else $error("transfer dropped"); // R2

   AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_ack, dma_ack})) else $error("double acknowledge"); // R12

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !enh_wr |=> irq) else $error("irq dropped"); // R10

   AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> err_pend) else $error("irq without fault"); // R10

   AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      err_pend && !enh_wr |=> $stable(cap_view)) else $error("capture overwritten"); // R9

endmodule

bind pbus_bridge pbus_bridge_chk #(.AW(AW), .DW(DW), .RAW(RAW)) u_chk (.*);

// File: tb/pbus_bridge_bench.sv
module pbus_bridge_bench;

   localparam int AW  = 16;
   localparam int DW  = 32;
   localparam int RAW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic           cpu_req = 0, cpu_we = 0, dma_req = 0, dma_we = 0;
   logic [1:0]     cpu_size = 0, dma_size = 0;
   logic [AW-1:0]  cpu_addr = 0, dma_addr = 0;
   logic [DW-1:0]  cpu_wdata = 0, dma_wdata = 0;
   logic           cpu_ack, dma_ack;
   logic [DW-1:0]  cpu_rdata, dma_rdata;
   logic           per_req, per_we, per_ready, per_abort;
   logic [1:0]     per_size, per_width;
   logic [AW-1:0]  per_addr;
   logic [DW-1:0]  per_wdata, per_rdata;
   logic           reg_en = 0, reg_we = 0;
   logic [RAW-1:0] reg_off = 0;
   logic [15:0]    reg_wdata = 0, reg_rdata;
   logic           irq;

   pbus_bridge #(.AW(AW), .DW(DW), .RAW(RAW), .HAS_PIPE(1'b1)) u_pbus_bridge (.*);

   // peripheral model: [15:14] 00 -> 8-bit, 01 -> 16-bit, else 32-bit;
   // [13:12] == 11 aborts; otherwise ready on the second transfer cycle
   int wcnt = 0;
   always_comb begin
      per_width = (per_addr[15:14] == 2'b00) ? 2'd0 :
                  (per_addr[15:14] == 2'b01) ? 2'd1 : 2'd2;
      per_abort = per_req && (per_addr[13:12] == 2'b11);
      per_ready = per_req && !per_abort && (wcnt == 1);
      per_rdata = per_req ? {~per_addr, per_addr} : '0;
   end
   always @(posedge clk) wcnt <= (per_req && !per_ready && !per_abort) ? wcnt + 1 : 0;

   int checks = 0, fails = 0, xfers = 0;
   logic [50:0] exp_q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: every finished peripheral transfer is compared in order (R4)
   always @(negedge clk) begin
      if (rst_n && per_req && (per_ready || per_abort)) begin
         xfers++;
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R4 unexpected transfer actual=%h expected=none",
                     {per_we, per_size, per_addr, per_wdata});
         end else begin
            chk("R4 transfer order/content", 32'({per_we, per_size, per_addr, per_wdata} != exp_q[0]), 32'd0);
            void'(exp_q.pop_front());
         end
      end
   end

   task automatic acc(input bit dma, input bit we, input logic [1:0] sz, input logic [15:0] a,
                      input logic [31:0] wd, input bit xfer, output int lat, output logic [31:0] rd);
      if (xfer) exp_q.push_back({we, sz, a, wd});
      @(posedge clk); #1;
      if (dma) begin dma_req = 1; dma_we = we; dma_size = sz; dma_addr = a; dma_wdata = wd; end
      else     begin cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd; end
      lat = 0;
      forever begin
         @(negedge clk);
         if (dma ? dma_ack : cpu_ack) begin rd = dma ? dma_rdata : cpu_rdata; break; end
         lat++;
      end
      @(posedge clk); #1;
      if (dma) dma_req = 0; else cpu_req = 0;
   endtask

   task automatic rwr(input logic [5:0] off, input logic [15:0] d);
      @(posedge clk); #1; reg_en = 1; reg_we = 1; reg_off = off; reg_wdata = d;
      @(posedge clk); #1; reg_en = 0; reg_we = 0;
   endtask

   task automatic rrd(input logic [5:0] off, output logic [15:0] d);
      @(posedge clk); #1; reg_en = 1; reg_we = 0; reg_off = off;
      @(negedge clk); d = reg_rdata;
      @(posedge clk); #1; reg_en = 0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      int lat, lat2; logic [31:0] rd, rd2; logic [15:0] v; int x0;
      repeat (3) @(posedge clk); #1 rst_n = 1;

      // R1 reset values and unmapped reads
      rrd(6'h00, v); chk("R1 ctl", 32'(v), 32'hFF11);
      rrd(6'h04, v); chk("R1 alloc", 32'(v), 32'h0009);
      rrd(6'h08, v); chk("R1 cpuctl", 32'(v), 32'h0000);
      rrd(6'h0C, v); chk("R1 enh", 32'(v), 32'hFFFF);
      rrd(6'h10, v); chk("R1 caddr", 32'(v), 32'hFFFF);
      rrd(6'h18, v); chk("R1 chi", 32'(v), 32'hFFFF);
      rrd(6'h1C, v); chk("R1 cctl", 32'(v), 32'h00F8);
      rrd(6'h20, v); chk("R1 unmapped", 32'(v), 32'h0);
      rrd(6'h06, v); chk("R1 unaligned", 32'(v), 32'h0);
      chk("R10 irq after reset", 32'(irq), 32'd0);

      rwr(6'h0C, 16'h0002);   // pipeline off, irq on
      // R3 non-posted write
      acc(0, 1, 2'd1, 16'h4010, 32'h0000BEEF, 1, lat, rd);
      chk("R3 write ack latency", lat, 3);
      // R5 read
      acc(0, 0, 2'd2, 16'h8024, 32'h0, 1, lat, rd);
      chk("R5 read latency", lat, 3);
      chk("R5 read data", rd, {~16'h8024, 16'h8024});

      // R2 posted write
      rwr(6'h08, 16'h0001);
      x0 = xfers;
      acc(0, 1, 2'd0, 16'h0100, 32'h000000A5, 1, lat, rd);
      chk("R2 posted ack latency", lat, 0);
      chk("R2 transfer not yet done at ack", xfers - x0, 0);
      repeat (4) @(posedge clk);
      chk("R2 transfer done later", xfers - x0, 1);

      // R4 posted write followed by a read that must wait
      acc(0, 1, 2'd1, 16'h4002, 32'h00001234, 1, lat, rd);
      acc(0, 0, 2'd1, 16'h4004, 32'h0, 1, lat2, rd2);
      chk("R4 posted write ack", lat, 0);
      chk("R4 read stalled", lat2, 5);
      chk("R4 read data", rd2, {~16'h4004, 16'h4004});

      // R7 size mismatch: 32-bit read at 8-bit device
      x0 = xfers;
      acc(0, 0, 2'd2, 16'h0008, 32'h0, 0, lat, rd);
      chk("R7 mismatch ack latency", lat, 1);
      chk("R7 mismatch rdata", rd, 0);
      repeat (3) @(posedge clk);
      chk("R7 no transfer", xfers - x0, 0);
      chk("R10 irq on mismatch", 32'(irq), 1);
      rrd(6'h10, v); chk("R9 cap addr", 32'(v), 32'h0008);
      rrd(6'h14, v); chk("R9 cap lo", 32'(v), 32'h0);
      rrd(6'h1C, v); chk("R9 cap ctl", 32'(v), 32'h0004);

      // R9 second fault (abort) does not overwrite
      acc(0, 0, 2'd1, 16'h7000, 32'h0, 1, lat, rd);
      chk("R5 abort read latency", lat, 2);
      chk("R5 abort rdata", rd, 0);
      rrd(6'h10, v); chk("R9 cap kept", 32'(v), 32'h0008);
      chk("R10 irq held", 32'(irq), 1);
      rwr(6'h0C, 16'h0006);
      @(negedge clk); chk("R10 irq cleared", 32'(irq), 0);

      // R8 posted write that aborts
      acc(0, 1, 2'd1, 16'h7010, 32'h12345678, 1, lat, rd);
      chk("R8 posted abort ack", lat, 0);
      repeat (4) @(posedge clk); @(negedge clk);
      chk("R8 irq raised", 32'(irq), 1);
      rrd(6'h10, v); chk("R8 cap addr", 32'(v), 32'h7010);
      rrd(6'h14, v); chk("R9 cap lo", 32'(v), 32'h5678);
      rrd(6'h18, v); chk("R9 cap hi", 32'(v), 32'h1234);
      rrd(6'h1C, v); chk("R8 cap ctl", 32'(v), 32'h00AB);

      // R11 writes to capture registers ignored
      rwr(6'h10, 16'h0000); rwr(6'h1C, 16'h0000);
      rrd(6'h10, v); chk("R11 caddr ro", 32'(v), 32'h7010);
      rrd(6'h1C, v); chk("R11 cctl ro", 32'(v), 32'h00AB);

      // R10 enable gating
      rwr(6'h0C, 16'h0004);   // clear, irq off
      acc(0, 0, 2'd1, 16'h0000, 32'h0, 0, lat, rd);
      repeat (2) @(posedge clk); @(negedge clk);
      chk("R10 irq masked", 32'(irq), 0);
      rwr(6'h0C, 16'h0002);
      @(negedge clk); chk("R10 irq unmasked", 32'(irq), 1);
      rwr(6'h0C, 16'h0006);
      @(negedge clk); chk("R10 irq cleared again", 32'(irq), 0);

      // R6 pipeline mode
      rwr(6'h0C, 16'h0003);
      acc(0, 1, 2'd2, 16'h8200, 32'hCAFEF00D, 1, lat, rd);
      chk("R6 posted ack with pipe", lat, 1);
      repeat (4) @(posedge clk);
      acc(1, 1, 2'd1, 16'h4300, 32'h00005555, 1, lat, rd);
      chk("R6 R12 dma write with pipe", lat, 4);

      // R12 DMA writes not posted, CPU priority
      rwr(6'h0C, 16'h0002);
      acc(1, 1, 2'd1, 16'h4400, 32'h00006666, 1, lat, rd);
      chk("R12 dma write not posted", lat, 3);
      rwr(6'h08, 16'h0000);
      exp_q.push_back({1'b0, 2'd1, 16'h4000, 32'h0});
      exp_q.push_back({1'b1, 2'd1, 16'h4100, 32'h00007777});
      fork
         acc(0, 0, 2'd1, 16'h4000, 32'h0, 0, lat, rd);
         acc(1, 1, 2'd1, 16'h4100, 32'h00007777, 0, lat2, rd2);
      join
      chk("R12 cpu first", lat, 3);
      chk("R12 dma waits", lat2, 7);
      chk("R12 cpu read data", rd, {~16'h4000, 16'h4000});

      repeat (4) @(posedge clk);
      chk("R4 all expected transfers seen", exp_q.size(), 0);
      finish_run();
   end

endmodule